// File: doc/BRIEF.md
# Input Clock Loss-of-Signal Alarm Monitor

This block watches several input clocks from a free-running reference clock and flags any input that stops pulsing. Each monitored clock is brought into the reference domain through a synchroniser. A counter then measures how long the input goes without a level change. If that gap grows past a threshold, the input is declared missing and its alarm rises.

An alarm is sticky. It falls only after its input has run clean for a programmable validation interval, counted in milliseconds from a shared prescaler. A fresh miss during that interval keeps the alarm up and restarts the count.

Each input has a 2-bit mode. The mode picks a tight detector, a more tolerant detector, or no monitoring at all. A summary output stays high while any per-input alarm is high. Clock selection logic downstream uses the per-input alarms to pick a healthy reference, and uses the summary as a single board-level flag.

Top module: `los_alarm_monitor`

## Requirements
- R1: With mode 2'b11 (tight detector), an input whose synchronised level shows no change for THR_STD consecutive reference cycles raises its alarm at the next reference edge. A level change at the pin reaches the detector after two reference edges.
- R2: A raised alarm falls on the N-th millisecond tick after the most recent miss, where N is the selected validation length. A tick occurs once every CYC_PER_MS reference cycles, counted from reset.
- R3: A miss on an input whose alarm is already high keeps the alarm high and restarts its validation count from zero.
- R4: The validation select encodes 2'b00 = VAL_MS_00 (2 ms), 2'b01 = VAL_MS_01 (100 ms), 2'b10 = VAL_MS_10 (200 ms) and 2'b11 = VAL_MS_11 (13000 ms).
- R5: With mode 2'b10 (tolerant detector), the threshold is THR_ALT reference cycles instead of THR_STD. Gaps shorter than THR_ALT raise no alarm.
- R6: With mode 2'b00 (off) or 2'b01 (reserved, treated as off), the alarm is low from the next edge on and the validation count is cleared. A stopped clock on that input has no effect.
- R7: The summary output is high exactly when at least one per-input alarm is high, and is updated on the same edge as the alarms.
- R8: A synchronous reset clears all alarms, the summary and all timers.
- R9: Each input is monitored on its own. The mode of input i sits in mode_i[2i+1:2i], and a fault on one input leaves the alarms of the others untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_clk_i | input | N_IN | Monitored clocks, asynchronous to clk_ref |
| mode_i | input | 2*N_IN | Per-input detector mode, input i at bits [2i+1:2i] |
| valsel_i | input | 2 | Validation interval select |
| alarm_o | output | N_IN | Per-input loss-of-signal alarm |
| summary_o | output | 1 | High while any alarm is high |

## Verification
Each input is driven with fast clocks, with slow clocks that have long gaps between edges, and with clocks stopped outright for a short burst or for good. The slow pattern is the one that separates the tight detector from the tolerant one: the same gap trips one mode and not the other. A stop burst in the middle of a validation run shows whether the interval restarts or merely continues. Resuming a clock under each validation select shows whether the alarm falls inside the window that the select encodes. Setting different modes and faults on the two inputs shows that they stay independent and that the summary waits for the last alarm to clear.

// File: rtl/los_mon_pkg.sv
package los_mon_pkg;

  typedef enum logic [1:0] {
    DET_OFF  = 2'b00,
    DET_RSVD = 2'b01,
    DET_ALT  = 2'b10,
    DET_STD  = 2'b11
  } det_mode_e;

  // monitoring is live only for the two detector codes
  function automatic logic det_active(input logic [1:0] m);
    return (m == DET_ALT) || (m == DET_STD);
  endfunction

  // gap length (reference cycles) that counts as a missing pulse
  function automatic int unsigned det_limit(input logic [1:0] m,
                                            input int unsigned thr_std,
                                            input int unsigned thr_alt);
    return (m == DET_ALT) ? thr_alt : thr_std;
  endfunction

  // validation interval in milliseconds for a select code
  function automatic int unsigned val_ms(input logic [1:0] sel,
                                         input int unsigned v00,
                                         input int unsigned v01,
                                         input int unsigned v10,
                                         input int unsigned v11);
    case (sel)
      2'b00:   return v00;
      2'b01:   return v01;
      2'b10:   return v10;
      default: return v11;
    endcase
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/los_ms_tick.sv
module los_ms_tick #(
  parameter int unsigned CYC_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;

  logic [PW-1:0] pcnt;
  logic          wrap;

  assign wrap   = (pcnt == PW'(CYC_PER_MS - 1));
  assign tick_o = wrap;

  always_ff @(posedge clk) begin
    if (rst)       pcnt <= '0;
    else if (wrap) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/los_edge_sync.sv
module los_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic tog_o
);
  // [0],[1] form the two-flop synchroniser, [2] holds the previous safe level
  logic [2:0] shr;

  always_ff @(posedge clk) begin
    if (rst) shr <= '0;
    else     shr <= {shr[1:0], async_i};
  end

  assign tog_o = shr[2] ^ shr[1];
endmodule

// File: rtl/los_miss_det.sv
module los_miss_det
  import los_mon_pkg::*;
#(
  parameter int unsigned THR_STD = 16,
  parameter int unsigned THR_ALT = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       tog_i,
  output logic       active_o,
  output logic       miss_o
);
  localparam int unsigned TMAX = umax(THR_STD, THR_ALT);
  localparam int unsigned CW   = $clog2(TMAX + 1);

  logic [CW-1:0] gap_q;
  logic [CW-1:0] lim;

  assign active_o = det_active(mode_i);
  assign lim      = CW'(det_limit(mode_i, THR_STD, THR_ALT) - 1);
  // >= so that a switch to the shorter threshold fires at once on a long gap
  assign miss_o   = active_o && !tog_i && (gap_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !active_o || tog_i || miss_o) gap_q <= '0;
    else                                     gap_q <= gap_q + 1'b1;
  end
endmodule

// File: rtl/los_val_timer.sv
module los_val_timer
  import los_mon_pkg::*;
#(
  parameter int unsigned VAL_MS_00 = 2,
  parameter int unsigned VAL_MS_01 = 100,
  parameter int unsigned VAL_MS_10 = 200,
  parameter int unsigned VAL_MS_11 = 13000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active_i,
  input  logic       miss_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       alarm_o,
  output logic       alarm_nx_o
);
  localparam int unsigned VMAX = umax(umax(VAL_MS_00, VAL_MS_01), umax(VAL_MS_10, VAL_MS_11));
  localparam int unsigned MW   = $clog2(VMAX + 1);

  logic [MW-1:0] ms_q, ms_d;
  logic [MW-1:0] tgt;
  logic          al_q, al_d;

  assign tgt = MW'(val_ms(sel_i, VAL_MS_00, VAL_MS_01, VAL_MS_10, VAL_MS_11) - 1);

  always_comb begin
    al_d = al_q;
    ms_d = ms_q;
    if (!active_i) begin
      al_d = 1'b0;
      ms_d = '0;
    end else if (miss_i) begin
      al_d = 1'b1;
      ms_d = '0;
    end else if (al_q && tick_i) begin
      if (ms_q >= tgt) begin
        al_d = 1'b0;
        ms_d = '0;
      end else begin
        ms_d = ms_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      al_q <= 1'b0;
      ms_q <= '0;
    end else begin
      al_q <= al_d;
      ms_q <= ms_d;
    end
  end

  assign alarm_o    = al_q;
  assign alarm_nx_o = al_d;
endmodule

// File: rtl/los_alarm_merge.sv
module los_alarm_merge #(
  parameter int unsigned N_IN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] alarm_nx_i,
  output logic            summary_o
);
  always_ff @(posedge clk) begin
    if (rst) summary_o <= 1'b0;
    else     summary_o <= |alarm_nx_i;
  end
endmodule

// File: rtl/los_alarm_monitor.sv
module los_alarm_monitor #(
  parameter int unsigned N_IN       = 2,
  parameter int unsigned CYC_PER_MS = 50000,
  parameter int unsigned THR_STD    = 16,
  parameter int unsigned THR_ALT    = 64,
  parameter int unsigned VAL_MS_00  = 2,
  parameter int unsigned VAL_MS_01  = 100,
  parameter int unsigned VAL_MS_10  = 200,
  parameter int unsigned VAL_MS_11  = 13000
) (
  input  logic              clk_ref,
  input  logic              rst,
  input  logic [N_IN-1:0]   mon_clk_i,
  input  logic [2*N_IN-1:0] mode_i,
  input  logic [1:0]        valsel_i,
  output logic [N_IN-1:0]   alarm_o,
  output logic              summary_o
);
  // named internal events, observed by the bound checker
  logic              tick_ms;
  logic [N_IN-1:0]   tog_evt;
  logic [N_IN-1:0]   miss_evt;
  logic [N_IN-1:0]   en_vec;
  logic [N_IN-1:0]   alarm_nx;

  los_ms_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
    .clk    (clk_ref),
    .rst    (rst),
    .tick_o (tick_ms)
  );

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_lane
    los_edge_sync u_sync (
      .clk     (clk_ref),
      .rst     (rst),
      .async_i (mon_clk_i[gi]),
      .tog_o   (tog_evt[gi])
    );

    los_miss_det #(.THR_STD(THR_STD), .THR_ALT(THR_ALT)) u_det (
      .clk      (clk_ref),
      .rst      (rst),
      .mode_i   (mode_i[2*gi +: 2]),
      .tog_i    (tog_evt[gi]),
      .active_o (en_vec[gi]),
      .miss_o   (miss_evt[gi])
    );

    los_val_timer #(
      .VAL_MS_00 (VAL_MS_00),
      .VAL_MS_01 (VAL_MS_01),
      .VAL_MS_10 (VAL_MS_10),
      .VAL_MS_11 (VAL_MS_11)
    ) u_val (
      .clk        (clk_ref),
      .rst        (rst),
      .active_i   (en_vec[gi]),
      .miss_i     (miss_evt[gi]),
      .tick_i     (tick_ms),
      .sel_i      (valsel_i),
      .alarm_o    (alarm_o[gi]),
      .alarm_nx_o (alarm_nx[gi])
    );
  end

  los_alarm_merge #(.N_IN(N_IN)) u_merge (
    .clk        (clk_ref),
    .rst        (rst),
    .alarm_nx_i (alarm_nx),
    .summary_o  (summary_o)
  );
endmodule

// File: rtl/los_alarm_monitor_chk.sv
module los_alarm_monitor_chk #(
  parameter int unsigned N_IN = 2
) (
  input logic            clk_ref,
  input logic            rst,
  input logic [N_IN-1:0] alarm_o,
  input logic            summary_o,
  input logic [N_IN-1:0] miss_evt,
  input logic [N_IN-1:0] en_vec,
  input logic            tick_ms
);
  for (genvar gi = 0; gi < N_IN; gi++) begin : g_lane_chk
    // R1
    miss_raises_chk: assert property (@(posedge clk_ref) disable iff (rst)
      miss_evt[gi] |=> alarm_o[gi]);

    // R3
    miss_holds_chk: assert property (@(posedge clk_ref) disable iff (rst)
      (alarm_o[gi] && miss_evt[gi]) |=> alarm_o[gi]);

    // R2
    clear_on_tick_chk: assert property (@(posedge clk_ref) disable iff (rst)
      ($past(en_vec[gi]) && $fell(alarm_o[gi])) |-> $past(tick_ms));

    // R6
    off_forces_low_chk: assert property (@(posedge clk_ref) disable iff (rst)
      !en_vec[gi] |=> !alarm_o[gi]);
  end

  // R7
  summary_high_chk: assert property (@(posedge clk_ref) disable iff (rst)
    (alarm_o != '0) |-> summary_o);

  // R7
  summary_low_chk: assert property (@(posedge clk_ref) disable iff (rst)
    (alarm_o == '0) |-> !summary_o);

  // R8
  reset_clear_chk: assert property (@(posedge clk_ref)
    rst |=> ((alarm_o == '0) && !summary_o));
endmodule

bind los_alarm_monitor los_alarm_monitor_chk #(.N_IN(N_IN)) u_chk (.*);

// File: tb/los_alarm_monitor_test.sv
module los_alarm_monitor_test;
  localparam int N     = 2;
  localparam int CYC   = 4;
  localparam int TSTD  = 8;
  localparam int TALT  = 32;
  localparam int V00 = 2, V01 = 100, V10 = 200, V11 = 13000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   mon = '0;
  logic [2*N-1:0] mode = '0;
  logic [1:0]     vsel = 2'b00;
  logic [N-1:0]   alarm;
  logic           summ;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int half  [N];
  int phase [N];

  always #10 clk = ~clk;

  los_alarm_monitor #(
    .N_IN(N), .CYC_PER_MS(CYC), .THR_STD(TSTD), .THR_ALT(TALT),
    .VAL_MS_00(V00), .VAL_MS_01(V01), .VAL_MS_10(V10), .VAL_MS_11(V11)
  ) uut (
    .clk_ref(clk), .rst(rst), .mon_clk_i(mon), .mode_i(mode),
    .valsel_i(vsel), .alarm_o(alarm), .summary_o(summ)
  );

  // ---------------- behavioural reference model ----------------
  int           m_gap [N];
  int           m_ms  [N];
  logic [N-1:0] m_alarm = '0;
  logic         m_sum = 1'b0;
  int           m_pc  = 0;
  bit           seen  [N][3];   // pin samples: [0] newest

  function automatic int sel_len(input logic [1:0] s);
    if (s == 2'b00) return V00;
    if (s == 2'b01) return V01;
    if (s == 2'b10) return V10;
    return V11;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_alarm = '0; m_sum = 0; m_pc = 0;
      for (int i = 0; i < N; i++) begin
        m_gap[i] = 0; m_ms[i] = 0;
        for (int k = 0; k < 3; k++) seen[i][k] = 0;
      end
    end else begin
      bit ms_edge;
      ms_edge = (m_pc == CYC - 1);
      for (int i = 0; i < N; i++) begin
        int  md;
        bit  on, chg, lost;
        md  = int'(mode[2*i +: 2]);
        on  = (md >= 2);
        chg = (seen[i][1] != seen[i][2]);
        if (!on) begin
          m_gap[i] = 0; m_ms[i] = 0; m_alarm[i] = 0;
        end else begin
          lost = !chg && (m_gap[i] + 1 >= ((md == 2) ? TALT : TSTD));
          m_gap[i] = (chg || lost) ? 0 : m_gap[i] + 1;
          if (lost) begin
            m_alarm[i] = 1; m_ms[i] = 0;
          end else if (m_alarm[i] && ms_edge) begin
            if (m_ms[i] + 1 >= sel_len(vsel)) begin
              m_alarm[i] = 0; m_ms[i] = 0;
            end else m_ms[i]++;
          end
        end
        seen[i][2] = seen[i][1];
        seen[i][1] = seen[i][0];
        seen[i][0] = mon[i];
      end
      m_sum = |m_alarm;
      m_pc  = ms_edge ? 0 : m_pc + 1;
    end
  end

  // cycle compare against the model
  always @(negedge clk) begin
    if (!done) begin
      tests++;
      if (alarm !== m_alarm || summ !== m_sum) begin
        fails++;
        $display("FAIL model R1 R2 R3 t=%0t alarm=%b/summary=%b expected %b/%b",
                 $time, alarm, summ, m_alarm, m_sum);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  initial begin
    for (int i = 0; i < N; i++) begin half[i] = 0; phase[i] = 0; end
    forever begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (half[i] != 0) begin
          phase[i]++;
          if (phase[i] >= half[i]) begin mon[i] = ~mon[i]; phase[i] = 0; end
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic set_mode(input int i, input logic [1:0] m);
    mode[2*i +: 2] = m;
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- directed scenarios ----------------
  initial begin
    step(5);
    chk("R8 reset alarms", alarm, 0);
    chk("R8 reset summary", summ, 0);
    rst = 0;

    // input0 tight detector with a fast clock, input1 off and stopped
    set_mode(0, 2'b11); set_mode(1, 2'b00); vsel = 2'b00;
    half[0] = 2;
    step(100);
    chk("R1 fast clock no alarm", alarm[0], 0);
    chk("R6 off input ignores stopped clock", alarm[1], 0);

    // stop input0
    half[0] = 0;
    step(TSTD + 4);
    chk("R1 stop raises alarm", alarm[0], 1);
    chk("R7 summary follows", summ, 1);

    // resume, 2 ms validation
    half[0] = 2;
    step(3);
    chk("R2 alarm held while validating", alarm[0], 1);
    step(14);
    chk("R2 alarm clears after validation", alarm[0], 0);
    chk("R7 summary clears", summ, 0);

    // restart on fresh miss, 100 ms validation
    vsel = 2'b01;
    half[0] = 0; step(20); half[0] = 2;
    step(300);
    chk("R3 still validating", alarm[0], 1);
    half[0] = 0; step(20); half[0] = 2;
    step(300);
    chk("R3 restarted count keeps alarm", alarm[0], 1);
    step(120);
    chk("R3 clears after full restarted interval", alarm[0], 0);

    // tolerant detector vs tight detector with the same slow clock
    vsel = 2'b00;
    set_mode(0, 2'b10); half[0] = 12;
    step(200);
    chk("R5 tolerant mode ignores 12-cycle gaps", alarm[0], 0);
    set_mode(0, 2'b11);
    step(30);
    chk("R5 tight mode flags the same gaps", alarm[0], 1);
    set_mode(0, 2'b10); half[0] = 2;
    step(20);
    chk("R5 tolerant mode clears on fast clock", alarm[0], 0);
    half[0] = 0;
    step(TALT + 4);
    chk("R5 tolerant mode flags a real stop", alarm[0], 1);

    // reserved and off codes
    set_mode(0, 2'b01);
    step(2);
    chk("R6 reserved code drops alarm", alarm[0], 0);
    step(100);
    chk("R6 reserved code ignores stopped clock", alarm[0], 0);
    set_mode(0, 2'b11);
    step(TSTD + 4);
    chk("R6 re-enabled detector sees stop", alarm[0], 1);
    set_mode(0, 2'b00);
    step(2);
    chk("R6 off code drops alarm", alarm[0], 0);
    step(50);
    chk("R6 off code ignores stopped clock", summ, 0);

    // two inputs independently
    set_mode(0, 2'b11); set_mode(1, 2'b11);
    half[0] = 2; half[1] = 3;
    step(50);
    chk("R9 both running", alarm, 2'b00);
    half[0] = 0; half[1] = 0;
    step(TSTD + 4);
    chk("R9 both stopped", alarm, 2'b11);
    half[0] = 2;
    step(20);
    chk("R9 input0 cleared alone", alarm, 2'b10);
    chk("R7 summary waits for last alarm", summ, 1);
    half[1] = 3;
    step(20);
    chk("R7 summary clears with last alarm", summ, 0);

    // 200 ms validation
    vsel = 2'b10;
    half[0] = 0; step(20); half[0] = 2;
    step(785);
    chk("R4 select 10 still high before 200 ms", alarm[0], 1);
    step(25);
    chk("R4 select 10 cleared after 200 ms", alarm[0], 0);

    // 13 s validation
    vsel = 2'b11;
    half[0] = 0; step(20); half[0] = 2;
    step(12999 * CYC - 20);
    chk("R4 select 11 still high before 13 s", alarm[0], 1);
    step(30);
    chk("R4 select 11 cleared after 13 s", alarm[0], 0);

    // reset in the middle of an alarm
    vsel = 2'b00;
    half[0] = 0;
    step(TSTD + 4);
    chk("R8 alarm up before reset", alarm[0], 1);
    rst = 1;
    step(2);
    chk("R8 reset clears alarms", alarm, 0);
    chk("R8 reset clears summary", summ, 0);
    rst = 0;
    step(5);

    finish_run();
  end
endmodule